// File: doc/BRIEF.md
# Dual-Modulus Feedback and Reference Divider with Synchronized Reload

This block holds the two programmable dividers of a frequency synthesizer. The feedback path models a prescaler that divides the input clock by 64 or 65. A swallow count A and a main count N steer that prescaler so that one feedback period lasts 64·N + A input clocks. The reference path divides a stream of reference ticks by a programmable ratio R. Each divider emits a single-cycle pulse when it reaches terminal count. A phase detector outside this block consumes those pulses. The modulus-control signal is also brought out.

New ratios arrive as write strobes from a register block. A and N are parked in a pending buffer. They become active only when the current feedback period ends, so a period never runs with a mix of old and new counts. A new R is parked too. At the next feedback terminal count it moves to an armed buffer, and the reference counter takes it up at its own next reload. This keeps the R update in step with the A/N update and never cuts a reference period short. Illegal values are mapped to legal ones before they are stored.

Top module: `dmd_top`

## Requirements
- R1: After reset the feedback period, measured from one `fb_pulse` to the next, is 64·N + A input clocks, and each `fb_pulse` lasts exactly one cycle.
- R2: Within each feedback period `mod_ctl` is high (divide-by-65) for the first A prescaler periods and low for the rest, so it is high for 65·A clocks per period.
- R3: An N value below 5 is used as 5; values from 5 to 4095 are used as written.
- R4: An A value (0 to 63) larger than the effective N is used as N.
- R5: An A/N write takes effect at the next feedback terminal count. The period in progress finishes with the old ratio, the next period uses the new one, and of several writes before that boundary the last wins.
- R6: `ref_pulse` follows every R-th cycle in which `ref_tick` is high, one cycle after it; with R = 1 every tick yields a pulse.
- R7: R values 0, 2, 3 and 4 are used as 5; 1 and 5 to 8191 are used as written.
- R8: An R write changes no reference interval until the next feedback terminal count has passed. After that boundary it is applied at the next reference reload.
- R9: Reset clears both pulse outputs and `mod_ctl` and starts with N = 5, A = 0, R = 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided (prescaler input) |
| rst_n | input | 1 | Active-low synchronous reset |
| an_wr | input | 1 | Strobe: capture `a_in` and `n_in` into the pending buffer |
| a_in | input | 6 | New swallow count A |
| n_in | input | 12 | New main count N |
| r_wr | input | 1 | Strobe: capture `r_in` into the pending buffer |
| r_in | input | 13 | New reference ratio R |
| ref_tick | input | 1 | One-cycle enable per reference-oscillator edge |
| fb_pulse | output | 1 | One-cycle pulse at feedback terminal count |
| ref_pulse | output | 1 | One-cycle pulse at reference terminal count |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = divide by 65 |

## Verification
The assertions check on every cycle that the stored A never exceeds N and that N and R stay within their legal sets. They also check that active ratios change only at their own terminal counts, that the modulus select holds still inside a prescaler period, and that the armed R appears only after a feedback terminal count. The exact period lengths, the 65·A high time of the modulus select, and the mapping of illegal values can only be shown by the bench's sweeps. So can which period first sees a new ratio and the delay of an R write behind the feedback boundary. The bench measures these from pulse to pulse.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  // Smallest legal main count; smaller requests are raised to it.
  function automatic int unsigned legal_n(int unsigned n, int unsigned n_min);
    return (n < n_min) ? n_min : n;
  endfunction

  // Swallow count may not exceed the main count.
  function automatic int unsigned legal_a(int unsigned a, int unsigned n);
    return (a > n) ? n : a;
  endfunction

  // Ratio 1 is pass-through; 0 and the gap below r_min map to r_min.
  function automatic int unsigned legal_r(int unsigned r, int unsigned r_min);
    if (r == 1) return 1;
    return (r < r_min) ? r_min : r;
  endfunction

  // Total feedback division for a prescaler of base 2**p_w.
  function automatic int unsigned fb_ratio(int unsigned n, int unsigned a, int unsigned p_w);
    return (n << p_w) + a;
  endfunction

endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int P_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_sel,
  output logic pres_tc
);
  localparam int P_BASE = 1 << P_W;

  logic [P_W:0] pc;
  logic [P_W:0] lim;

  assign lim     = mod_sel ? (P_W+1)'(P_BASE) : (P_W+1)'(P_BASE - 1);
  assign pres_tc = (pc == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)       pc <= '0;
    else if (pres_tc) pc <= '0;
    else              pc <= pc + 1'b1;
  end

  p_pc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= (P_W+1)'(P_BASE));

endmodule

// File: rtl/dmd_fb_counter.sv
module dmd_fb_counter #(
  parameter int A_W   = 6,
  parameter int N_W   = 12,
  parameter int N_MIN = 5,
  parameter int RST_N = 5,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           an_wr,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  input  logic           pres_tc,
  output logic           mod_sel,
  output logic           fb_tc
);
  logic [N_W-1:0] k;
  logic [A_W-1:0] a_act, a_pend;
  logic [N_W-1:0] n_act, n_pend;
  logic           pend_v;
  logic [N_W-1:0] n_wr_legal;
  logic [A_W-1:0] a_wr_legal;

  assign n_wr_legal = N_W'(dmd_pkg::legal_n(32'(n_in), N_MIN));
  assign a_wr_legal = A_W'(dmd_pkg::legal_a(32'(a_in), 32'(n_wr_legal)));

  assign mod_sel = (k < N_W'(a_act));
  assign fb_tc   = pres_tc && (k == n_act - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k      <= '0;
      a_act  <= A_W'(RST_A);
      n_act  <= N_W'(RST_N);
      a_pend <= '0;
      n_pend <= '0;
      pend_v <= 1'b0;
    end else begin
      if (fb_tc) begin
        k <= '0;
        if (pend_v) begin
          a_act <= a_pend;
          n_act <= n_pend;
        end
      end else if (pres_tc) begin
        k <= k + 1'b1;
      end
      // A write in the boundary cycle stays pending for the next boundary.
      if (an_wr) begin
        a_pend <= a_wr_legal;
        n_pend <= n_wr_legal;
        pend_v <= 1'b1;
      end else if (fb_tc) begin
        pend_v <= 1'b0;
      end
    end
  end

  p_a_le_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
    N_W'(a_act) <= n_act);
  p_n_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    n_act >= N_W'(N_MIN));
  p_an_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_tc |=> ($stable(a_act) && $stable(n_act)));

endmodule

// File: rtl/dmd_ref_counter.sv
module dmd_ref_counter #(
  parameter int R_W   = 13,
  parameter int R_MIN = 5,
  parameter int RST_R = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           r_wr,
  input  logic [R_W-1:0] r_in,
  input  logic           fb_tc,
  input  logic           ref_tick,
  output logic           ref_tc
);
  logic [R_W-1:0] rc;
  logic [R_W-1:0] r_act, r_arm, r_pend;
  logic           arm_v, pend_v;
  logic [R_W-1:0] r_wr_legal;

  assign r_wr_legal = R_W'(dmd_pkg::legal_r(32'(r_in), R_MIN));
  assign ref_tc     = ref_tick && (rc == r_act - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc     <= '0;
      r_act  <= R_W'(RST_R);
      r_arm  <= '0;
      r_pend <= '0;
      arm_v  <= 1'b0;
      pend_v <= 1'b0;
    end else begin
      if (ref_tc) begin
        rc <= '0;
        if (arm_v) r_act <= r_arm;
      end else if (ref_tick) begin
        rc <= rc + 1'b1;
      end
      // Second buffer stage: pending moves to armed at the feedback boundary.
      if (fb_tc && pend_v) begin
        r_arm <= r_pend;
        arm_v <= 1'b1;
      end else if (ref_tc) begin
        arm_v <= 1'b0;
      end
      if (r_wr) begin
        r_pend <= r_wr_legal;
        pend_v <= 1'b1;
      end else if (fb_tc) begin
        pend_v <= 1'b0;
      end
    end
  end

  p_r_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_act == R_W'(1)) || (r_act >= R_W'(R_MIN)));
  p_r_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tc |=> $stable(r_act));
  p_arm_after_fb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_v) |-> $past(fb_tc));

endmodule

// File: rtl/dmd_top.sv
module dmd_top #(
  parameter int P_W   = 6,
  parameter int A_W   = 6,
  parameter int N_W   = 12,
  parameter int R_W   = 13,
  parameter int N_MIN = 5,
  parameter int R_MIN = 5,
  parameter int RST_N = 5,
  parameter int RST_A = 0,
  parameter int RST_R = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           an_wr,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  input  logic           r_wr,
  input  logic [R_W-1:0] r_in,
  input  logic           ref_tick,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           mod_ctl
);
  logic mod_sel;
  logic pres_tc;
  logic fb_tc;
  logic ref_tc;

  dmd_prescaler #(.P_W(P_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_sel (mod_sel),
    .pres_tc (pres_tc)
  );

  dmd_fb_counter #(
    .A_W(A_W), .N_W(N_W), .N_MIN(N_MIN), .RST_N(RST_N), .RST_A(RST_A)
  ) u_fb (
    .clk     (clk),
    .rst_n   (rst_n),
    .an_wr   (an_wr),
    .a_in    (a_in),
    .n_in    (n_in),
    .pres_tc (pres_tc),
    .mod_sel (mod_sel),
    .fb_tc   (fb_tc)
  );

  dmd_ref_counter #(.R_W(R_W), .R_MIN(R_MIN), .RST_R(RST_R)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .r_wr     (r_wr),
    .r_in     (r_in),
    .fb_tc    (fb_tc),
    .ref_tick (ref_tick),
    .ref_tc   (ref_tc)
  );

  assign mod_ctl = mod_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      fb_pulse  <= fb_tc;
      ref_pulse <= ref_tc;
    end
  end

  p_mod_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_tc |=> $stable(mod_sel));
  p_fb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);
  p_ref_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick));

endmodule

// File: tb/dmd_top_tb_top.sv
module dmd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_wr = 1'b0;
  logic [5:0]  a_in = '0;
  logic [11:0] n_in = '0;
  logic        r_wr = 1'b0;
  logic [12:0] r_in = '0;
  logic        ref_tick = 1'b1;
  logic        fb_pulse, ref_pulse, mod_ctl;

  int checks = 0, failures = 0;
  int cyc = 0, fb_prev = 0, fb_last = 0, fb_cnt = 0, mod_acc = 0, mod_last = 0;
  int ref_prev = 0, ref_last = 0, ref_cnt = 0;
  int cur_n = 5, cur_a = 0, cur_r = 5;
  bit gap_mode = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmd_top dut_i (
    .clk(clk), .rst_n(rst_n), .an_wr(an_wr), .a_in(a_in), .n_in(n_in),
    .r_wr(r_wr), .r_in(r_in), .ref_tick(ref_tick),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .mod_ctl(mod_ctl)
  );

  // Pulse-to-pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (fb_pulse) begin
        fb_last = cyc - fb_prev; fb_prev = cyc; fb_cnt = fb_cnt + 1;
        mod_last = mod_acc; mod_acc = 0;
      end
      mod_acc = mod_acc + int'(mod_ctl);
      if (ref_pulse) begin
        ref_last = cyc - ref_prev; ref_prev = cyc; ref_cnt = ref_cnt + 1;
      end
      if (gap_mode) ref_tick = ~ref_tick;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fb(input int k);
    int target = fb_cnt + k;
    while (fb_cnt < target) @(posedge clk);
  endtask

  task automatic wait_ref(input int k);
    int target = ref_cnt + k;
    while (ref_cnt < target) @(posedge clk);
  endtask

  // Bench view of the legal mapping.
  function automatic int eff_n(int n); return (n >= 5) ? n : 5; endfunction
  function automatic int eff_a(int a, int n); return (eff_n(n) < a) ? eff_n(n) : a; endfunction
  function automatic int eff_r(int r);
    if (r == 1 || r >= 5) return r;
    return 5;
  endfunction

  task automatic write_an(input int a, input int n);
    @(negedge clk); a_in = 6'(a); n_in = 12'(n); an_wr = 1'b1;
    @(negedge clk); an_wr = 1'b0;
  endtask

  task automatic write_r(input int r);
    @(negedge clk); r_in = 13'(r); r_wr = 1'b1;
    @(negedge clk); r_wr = 1'b0;
  endtask

  // R5: old ratio finishes, new ratio follows; R1/R2 on the new period.
  task automatic an_case(input int a, input int n, input string req);
    int na, nn;
    nn = eff_n(n); na = eff_a(a, n);
    wait_fb(1);
    write_an(a, n);
    wait_fb(1);
    check(fb_last == cur_n * 64 + cur_a, "R5 old period", fb_last, cur_n * 64 + cur_a);
    wait_fb(1);
    check(fb_last == nn * 64 + na, req, fb_last, nn * 64 + na);
    check(mod_last == 65 * na, "R2 mod high time", mod_last, 65 * na);
    cur_n = nn; cur_a = na;
  endtask

  // R8 deferral and R6/R7 new interval.
  task automatic r_case(input int r, input string req);
    wait_fb(1);
    write_r(r);
    wait_ref(2);
    check(ref_last == cur_r, "R8 old ref interval", ref_last, cur_r);
    wait_fb(1);
    wait_ref(2);
    cur_r = eff_r(r);
    check(ref_last == cur_r, req, ref_last, cur_r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: reset state
    check(fb_pulse == 1'b0, "R9 fb_pulse after reset", int'(fb_pulse), 0);
    check(ref_pulse == 1'b0, "R9 ref_pulse after reset", int'(ref_pulse), 0);
    check(mod_ctl == 1'b0, "R9 mod_ctl after reset", int'(mod_ctl), 0);
    wait_fb(2);
    check(fb_last == 320, "R9 R1 default feedback period", fb_last, 320);
    check(mod_last == 0, "R2 no swallow at A=0", mod_last, 0);
    wait_ref(2);
    check(ref_last == 5, "R9 default ref interval", ref_last, 5);

    // Sweep over a small range of N and A corners.
    for (int n = 5; n <= 8; n++) begin
      an_case(0, n, "R1 period A=0");
      an_case(1, n, "R1 period A=1");
      an_case(n - 1, n, "R1 period A=N-1");
      an_case(n, n, "R1 period A=N");
    end
    an_case(9, 6, "R4 A clamped to N");
    an_case(63, 7, "R4 A=63 clamped to N");
    an_case(2, 3, "R3 N raised to 5");
    an_case(0, 0, "R3 N=0 raised to 5");
    an_case(20, 40, "R1 period larger N");

    // R5: last of back-to-back writes wins.
    wait_fb(1);
    write_an(3, 7);
    write_an(2, 9);
    wait_fb(1);
    check(fb_last == cur_n * 64 + cur_a, "R5 old period before writes", fb_last, cur_n * 64 + cur_a);
    wait_fb(1);
    check(fb_last == 9 * 64 + 2, "R5 last write wins", fb_last, 9 * 64 + 2);
    cur_n = 9; cur_a = 2;

    // Reference ratios.
    r_case(1, "R6 pass-through R=1");
    r_case(3, "R7 R=3 used as 5");
    r_case(13, "R6 R=13");
    r_case(0, "R7 R=0 used as 5");
    r_case(2, "R7 R=2 used as 5");
    r_case(7, "R6 R=7");

    // R6: gapped reference ticks, every other cycle.
    gap_mode = 1'b1;
    wait_ref(3);
    check(ref_last == 2 * cur_r, "R6 gapped ticks", ref_last, 2 * cur_r);
    gap_mode = 1'b0;
    @(negedge clk); ref_tick = 1'b1;

    // R5 with R8 together: both switch at the same feedback boundary.
    wait_fb(1);
    write_an(4, 6);
    write_r(11);
    wait_fb(1);
    check(fb_last == cur_n * 64 + cur_a, "R5 old period combined", fb_last, cur_n * 64 + cur_a);
    wait_ref(2);
    check(ref_last == 11, "R8 R applied after boundary", ref_last, 11);
    wait_fb(1);
    check(fb_last == 6 * 64 + 4, "R5 new period combined", fb_last, 6 * 64 + 4);

    finish_run();
  end

endmodule